// File: doc/BRIEF.md
# UART Register File and Interrupt Logic

This block is the register window of a serial port. A bus master makes single-cycle accesses to a 4 KB region. The address arrives as a word index, so each register takes one 32-bit slot. Stored settings cover the baud divisors, low-power divisor, line control, control, FIFO level select, DMA control and interrupt mask. Read-only views show the transmit/receive flags, the raw interrupt bits and the masked interrupt bits. A write-one-to-clear port clears the raw interrupt bits. The top eight words of the window return constant identification bytes.

A write to the data slot passes its low byte straight to the transmitter as a one-cycle strobe and marks the transmit interrupt. A read of the data slot returns the head of an external receive FIFO and pulses a pop strobe.

The FIFO reports its occupancy and each arriving entry. From these the block raises or drops the receive interrupt at a programmable trigger level. A single level interrupt output is the OR of the raw bits that the mask enables.

Top module: `uart_regfile`

## Requirements
- R1: After reset the mask, raw status and control registers read 0, `irq` is low, and with `rx_count` at 0 the flag word reads 0x90.
- R2: Word indexes decode as follows, and each stored register reads back its written value truncated to its width:
  - 8: low-power divisor, 8 bits.
  - 9: integer baud, 16 bits.
  - 10: fractional baud, 6 bits.
  - 11: line control, 8 bits.
  - 12: control, 16 bits.
  - 13: FIFO level select, 6 bits.
  - 14: mask, 11 bits.
  - 18: DMA control, 3 bits.
- R3: Reads of word indexes 0x3F8 through 0x3FF return identification byte `index-0x3F8` from parameter `ID_BYTES`, with byte 0 in bits 7:0.
- R4: A write to index 0 asserts `tx_valid` with `tx_byte = wdata[7:0]` in that cycle. From the next cycle, raw status bit 5 is set.
- R5: A write to index 17 clears every raw status bit whose `wdata` bit is 1, and leaves the other raw bits unchanged.
- R6: `irq` is high exactly when raw status AND mask is nonzero, from the cycle after the change. Index 16 reads that AND and index 15 reads the raw bits.
- R7: Writes to index 6 have no effect. The flag word is defined as follows:
  - bit 7 is always 1 (transmit empty);
  - bit 5 is always 0 (transmit full);
  - bit 4 is 1 when `rx_count` is 0;
  - bit 6 is 1 when `rx_count` equals the depth, or when line control bit 4 is 0 and `rx_count` is at least 1.
- R8: A read of index 0 returns `rx_data` zero-extended. It pulses `rx_pop` in that cycle only when `rx_count` is nonzero.
- R9: The receive trigger level is 4 times FIFO-level bits 5:3 when line control bit 4 is 1, and 1 otherwise. A lone push that brings the count up to the trigger sets raw bit 4. A lone pop that takes the count from the trigger to the trigger minus one clears raw bit 4.
- R10: Undecoded accesses read 0, change nothing and pulse `err` for that cycle. Undecoded accesses are:
  - reads of index 17;
  - writes to indexes 15 and 16;
  - writes to the identification words;
  - any other unlisted index.
- R11: When a clear write to index 17 meets a push that sets raw bit 4 in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Access valid this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Word index within the 4 KB window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the access cycle |
| err | output | 1 | Pulse for an undecoded access |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_data | input | 12 | Head entry of the receive FIFO |
| rx_count | input | 5 | Receive FIFO occupancy |
| rx_push | input | 1 | One entry entered the receive FIFO |
| rx_pop | output | 1 | Remove the head entry |

## Verification
The receive-trigger set and the write-one-to-clear port can both act on raw bit 4 in the same cycle. The bench provokes this by driving `rx_push` while the count sits one below the trigger, during the very cycle that writes 0x10 to the clear register. The raw view must then read 0x10. A following clear write alone must then read 0, which shows that the order, not a stuck bit, decided the result.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int RAW_W   = 11;
  localparam int TX_BIT  = 5;
  localparam int RX_BIT  = 4;
  localparam int ILP_W   = 8;
  localparam int IBRD_W  = 16;
  localparam int FBRD_W  = 6;
  localparam int LCTL_W  = 8;
  localparam int CTL_W   = 16;
  localparam int FLVL_W  = 6;
  localparam int DMA_W   = 3;
  localparam int FEN_BIT = 4;
  localparam logic [FLVL_W-1:0] FLVL_RST = 6'h12;

  localparam int IX_DATA = 0;
  localparam int IX_FLAG = 6;
  localparam int IX_ILP  = 8;
  localparam int IX_IBRD = 9;
  localparam int IX_FBRD = 10;
  localparam int IX_LCTL = 11;
  localparam int IX_CTL  = 12;
  localparam int IX_FLVL = 13;
  localparam int IX_MASK = 14;
  localparam int IX_RAW  = 15;
  localparam int IX_MST  = 16;
  localparam int IX_CLR  = 17;
  localparam int IX_DMA  = 18;
  localparam int ID_N    = 8;

  typedef enum logic [3:0] {
    RG_NONE, RG_DATA, RG_FLAG, RG_ILP, RG_IBRD, RG_FBRD, RG_LCTL, RG_CTL,
    RG_FLVL, RG_MASK, RG_RAW, RG_MST, RG_CLR, RG_DMA, RG_ID
  } reg_e;

  // Receive trigger level: a quarter-step count taken from the level field
  // when the FIFO is on, a single entry when it is off.
  function automatic int rx_trigger(input logic fen, input logic [FLVL_W-1:0] lvl);
    return fen ? int'(lvl[5:3]) * 4 : 1;
  endfunction

  function automatic logic [7:0] flag_byte(input int count, input int depth, input logic fen);
    logic [7:0] f;
    f    = '0;
    f[7] = 1'b1;
    f[4] = (count == 0);
    f[6] = (count >= depth) || (!fen && count >= 1);
    return f;
  endfunction
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output reg_e          rsel,
  output logic          bad
);
  localparam int ID_BASE = (1 << AW) - ID_N;

  always_comb begin
    rsel = RG_NONE;
    if (int'(addr) >= ID_BASE) begin
      rsel = wr ? RG_NONE : RG_ID;
    end else begin
      case (int'(addr))
        IX_DATA: rsel = RG_DATA;
        IX_FLAG: rsel = RG_FLAG;
        IX_ILP:  rsel = RG_ILP;
        IX_IBRD: rsel = RG_IBRD;
        IX_FBRD: rsel = RG_FBRD;
        IX_LCTL: rsel = RG_LCTL;
        IX_CTL:  rsel = RG_CTL;
        IX_FLVL: rsel = RG_FLVL;
        IX_MASK: rsel = RG_MASK;
        IX_RAW:  rsel = wr ? RG_NONE : RG_RAW;
        IX_MST:  rsel = wr ? RG_NONE : RG_MST;
        IX_CLR:  rsel = wr ? RG_CLR : RG_NONE;
        IX_DMA:  rsel = RG_DMA;
        default: rsel = RG_NONE;
      endcase
    end
    bad = sel && (rsel == RG_NONE);
  end
endmodule

// File: rtl/uart_rf_rxtrig.sv
module uart_rf_rxtrig
  import uart_rf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              fen,
  input  logic [FLVL_W-1:0] flvl,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_push,
  input  logic              pop,
  output logic              rx_set,
  output logic              rx_clr,
  output logic [7:0]        flags
);
  int cnt;
  int trig;

  always_comb begin
    cnt    = int'(rx_count);
    trig   = rx_trigger(fen, flvl);
    rx_set = rx_push && !pop && (cnt + 1 == trig);
    rx_clr = pop && !rx_push && (cnt == trig);
    flags  = flag_byte(cnt, DEPTH, fen);
  end
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic [RAW_W-1:0] mask_wd,
  input  logic             clr_we,
  input  logic [RAW_W-1:0] clr_wd,
  input  logic             tx_set,
  input  logic             rx_set,
  input  logic             rx_clr,
  output logic [RAW_W-1:0] raw_q,
  output logic [RAW_W-1:0] mask_q,
  output logic             irq
);
  logic [RAW_W-1:0] raw_next;

  // Clears first, then sets: an event arriving with a clear survives.
  always_comb begin
    raw_next = raw_q;
    if (clr_we) raw_next = raw_next & ~clr_wd;
    if (rx_clr) raw_next[RX_BIT] = 1'b0;
    if (tx_set) raw_next[TX_BIT] = 1'b1;
    if (rx_set) raw_next[RX_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= raw_next;
      if (mask_we) mask_q <= mask_wd;
    end
  end

  assign irq = |(raw_q & mask_q);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int          AW       = 10,
  parameter int          DW       = 16,
  parameter int          RXD_W    = 12,
  parameter int          DEPTH    = 16,
  parameter int          CNT_W    = $clog2(DEPTH + 1),
  parameter logic [63:0] ID_BYTES = 64'h96C3_5AA5_0007_213C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             err,
  output logic             irq,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  input  logic [RXD_W-1:0] rx_data,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  output logic             rx_pop
);
  reg_e             rsel;
  logic             wr_hit;
  logic             rd_hit;
  logic [ILP_W-1:0]  ilp_q;
  logic [IBRD_W-1:0] ibrd_q;
  logic [FBRD_W-1:0] fbrd_q;
  logic [LCTL_W-1:0] lctl_q;
  logic [CTL_W-1:0]  ctl_q;
  logic [FLVL_W-1:0] flvl_q;
  logic [DMA_W-1:0]  dma_q;
  logic [RAW_W-1:0]  raw_q;
  logic [RAW_W-1:0]  mask_q;
  logic [7:0]        flag_val;
  logic              rx_set;
  logic              rx_clr;
  logic [7:0]        id_arr [ID_N];

  uart_rf_decode #(.AW(AW)) u_dec (
    .sel(sel), .wr(wr), .addr(addr), .rsel(rsel), .bad(err)
  );

  assign wr_hit   = sel && wr;
  assign rd_hit   = sel && !wr;
  assign tx_valid = wr_hit && (rsel == RG_DATA);
  assign tx_byte  = wdata[7:0];
  assign rx_pop   = rd_hit && (rsel == RG_DATA) && (rx_count != '0);

  uart_rf_rxtrig #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
    .fen(lctl_q[FEN_BIT]), .flvl(flvl_q), .rx_count(rx_count),
    .rx_push(rx_push), .pop(rx_pop), .rx_set(rx_set), .rx_clr(rx_clr),
    .flags(flag_val)
  );

  uart_rf_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .mask_we(wr_hit && rsel == RG_MASK), .mask_wd(wdata[RAW_W-1:0]),
    .clr_we(wr_hit && rsel == RG_CLR), .clr_wd(wdata[RAW_W-1:0]),
    .tx_set(tx_valid), .rx_set(rx_set), .rx_clr(rx_clr),
    .raw_q(raw_q), .mask_q(mask_q), .irq(irq)
  );

  for (genvar g = 0; g < ID_N; g++) begin : g_id
    assign id_arr[g] = ID_BYTES[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ilp_q  <= '0;
      ibrd_q <= '0;
      fbrd_q <= '0;
      lctl_q <= '0;
      ctl_q  <= '0;
      flvl_q <= FLVL_RST;
      dma_q  <= '0;
    end else if (wr_hit) begin
      case (rsel)
        RG_ILP:  ilp_q  <= wdata[ILP_W-1:0];
        RG_IBRD: ibrd_q <= wdata[IBRD_W-1:0];
        RG_FBRD: fbrd_q <= wdata[FBRD_W-1:0];
        RG_LCTL: lctl_q <= wdata[LCTL_W-1:0];
        RG_CTL:  ctl_q  <= wdata[CTL_W-1:0];
        RG_FLVL: flvl_q <= wdata[FLVL_W-1:0];
        RG_DMA:  dma_q  <= wdata[DMA_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      case (rsel)
        RG_DATA: rdata = DW'(rx_data);
        RG_FLAG: rdata = DW'(flag_val);
        RG_ILP:  rdata = DW'(ilp_q);
        RG_IBRD: rdata = DW'(ibrd_q);
        RG_FBRD: rdata = DW'(fbrd_q);
        RG_LCTL: rdata = DW'(lctl_q);
        RG_CTL:  rdata = DW'(ctl_q);
        RG_FLVL: rdata = DW'(flvl_q);
        RG_MASK: rdata = DW'(mask_q);
        RG_RAW:  rdata = DW'(raw_q);
        RG_MST:  rdata = DW'(raw_q & mask_q);
        RG_DMA:  rdata = DW'(dma_q);
        RG_ID:   rdata = DW'(id_arr[addr[2:0]]);
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_rf_checker.sv
module uart_rf_checker
  import uart_rf_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             wr,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic             err,
  input logic             irq,
  input logic             tx_valid,
  input logic             rx_pop,
  input logic             rx_push,
  input logic [CNT_W-1:0] rx_count,
  input logic [RAW_W-1:0] raw_q,
  input logic [RAW_W-1:0] mask_q,
  input logic [7:0]       flag_val,
  input logic             rx_set
);
  logic clr_wr;
  assign clr_wr = sel && wr && (addr == AW'(IX_CLR));

  AST_TX_RAISES_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> raw_q[TX_BIT]); // R4
  AST_CLR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !rx_push) |=> ((raw_q & $past(wdata[RAW_W-1:0])) == '0)); // R5
  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R6
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(sel && wr) || $past(rx_push))); // R6
  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> (flag_val[4] && flag_val[7] && !flag_val[5])); // R7
  AST_POP_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (sel && !wr && addr == AW'(IX_DATA) && rx_count != '0)); // R8
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!tx_valid && !rx_pop)); // R10
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && wdata[RX_BIT] && rx_set) |=> raw_q[RX_BIT]); // R11
endmodule

bind uart_regfile uart_rf_checker #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
  .err(err), .irq(irq), .tx_valid(tx_valid), .rx_pop(rx_pop),
  .rx_push(rx_push), .rx_count(rx_count), .raw_q(raw_q), .mask_q(mask_q),
  .flag_val(flag_val), .rx_set(rx_set)
);

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, rx_push = 1'b0;
  logic [9:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [11:0] rx_data = '0;
  logic [4:0]  rx_count = '0;
  logic [15:0] rdata;
  logic        err, irq, tx_valid, rx_pop;
  logic [7:0]  tx_byte;

  int n_chk = 0, n_bad = 0;
  logic last_err, last_pop, last_txv;
  logic [7:0] last_txb;

  typedef struct { logic [15:0] exp; string tag; } exp_t;
  exp_t sb [$];

  localparam logic [63:0] IDS = 64'h96C3_5AA5_0007_213C;

  always #2 clk = ~clk;

  uart_regfile dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .err(err), .irq(irq), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .rx_data(rx_data), .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a read is on the bus.
  always @(negedge clk) begin
    if (sel && !wr) begin
      if (sb.size() == 0) begin
        chk("scoreboard underrun", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, {16'h0, rdata}, {16'h0, e.exp});
      end
    end
  end

  task automatic bus_rd(input logic [9:0] a, input logic [15:0] exp, input string tag);
    exp_t e;
    @(posedge clk); #1;
    sel = 1'b1; wr = 1'b0; addr = a;
    e.exp = exp; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    last_err = err; last_pop = rx_pop;
    @(posedge clk); #1;
    sel = 1'b0;
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [15:0] d, input logic push);
    @(posedge clk); #1;
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d; rx_push = push;
    @(negedge clk);
    last_err = err; last_txv = tx_valid; last_txb = tx_byte;
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0; rx_push = 1'b0;
  endtask

  task automatic push_rx();
    @(posedge clk); #1; rx_push = 1'b1;
    @(posedge clk); #1; rx_push = 1'b0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq low", irq, 0);
    bus_rd(14, 16'h0000, "R1 mask reset");
    bus_rd(15, 16'h0000, "R1 raw reset");
    bus_rd(12, 16'h0000, "R1 control reset");
    bus_rd(6,  16'h0090, "R1 flag reset");

    // R2 stored registers and truncation
    bus_wr(9,  16'hABCD, 0); bus_rd(9,  16'hABCD, "R2 integer baud");
    bus_wr(10, 16'hFFFF, 0); bus_rd(10, 16'h003F, "R2 fractional baud");
    bus_wr(11, 16'h1270, 0); bus_rd(11, 16'h0070, "R2 line control");
    bus_wr(12, 16'h0301, 0); bus_rd(12, 16'h0301, "R2 control");
    bus_wr(13, 16'hFFFF, 0); bus_rd(13, 16'h003F, "R2 level select");
    bus_wr(8,  16'h01A5, 0); bus_rd(8,  16'h00A5, "R2 low-power divisor");
    bus_wr(18, 16'hFFFF, 0); bus_rd(18, 16'h0007, "R2 dma control");
    bus_wr(14, 16'hFFFF, 0); bus_rd(14, 16'h07FF, "R2 mask");
    bus_wr(14, 16'h0000, 0);
    bus_wr(13, 16'h0012, 0);

    // R3 identification window
    for (int i = 0; i < 8; i++)
      bus_rd(10'h3F8 + 10'(i), {8'h0, IDS[8*i +: 8]}, "R3 id byte");

    // R4 transmit
    bus_wr(0, 16'h01A5, 0);
    chk("R4 tx_valid", last_txv, 1);
    chk("R4 tx_byte", last_txb, 8'hA5);
    bus_rd(15, 16'h0020, "R4 raw tx bit");
    chk("R6 irq masked off", irq, 0);

    // R6 mask and masked view
    bus_wr(14, 16'h0020, 0);
    chk("R6 irq on", irq, 1);
    bus_rd(16, 16'h0020, "R6 masked status");
    bus_wr(14, 16'h0010, 0);
    chk("R6 irq off", irq, 0);
    bus_rd(16, 16'h0000, "R6 masked status zero");

    // R5 clear
    bus_wr(17, 16'h0020, 0);
    bus_rd(15, 16'h0000, "R5 raw cleared");

    // R7 flags
    bus_wr(6, 16'h0000, 0);
    bus_rd(6, 16'h0090, "R7 flag write ignored");
    rx_count = 5'd3;  bus_rd(6, 16'h0080, "R7 partly filled");
    rx_count = 5'd16; bus_rd(6, 16'h00C0, "R7 full");
    bus_wr(11, 16'h0060, 0);
    rx_count = 5'd1;  bus_rd(6, 16'h00C0, "R7 fifo off full");
    bus_wr(11, 16'h0070, 0);
    rx_count = 5'd0;

    // R8 data read and pop
    rx_data = 12'h441; rx_count = 5'd2;
    bus_rd(0, 16'h0441, "R8 data");
    chk("R8 pop", last_pop, 1);
    rx_count = 5'd0;
    bus_rd(0, 16'h0441, "R8 data empty");
    chk("R8 no pop when empty", last_pop, 0);

    // R9 trigger at 8
    rx_count = 5'd7; push_rx(); rx_count = 5'd8;
    bus_rd(15, 16'h0010, "R9 trigger set");
    chk("R9 irq", irq, 1);
    bus_rd(0, 16'h0441, "R9 pop read"); rx_count = 5'd7;
    bus_rd(15, 16'h0000, "R9 trigger clear");
    chk("R9 irq low", irq, 0);
    bus_wr(11, 16'h0060, 0);
    rx_count = 5'd0; push_rx(); rx_count = 5'd1;
    bus_rd(15, 16'h0010, "R9 fifo off trigger 1");
    bus_wr(17, 16'h0010, 0);
    bus_wr(11, 16'h0070, 0);

    // R11 collision
    rx_count = 5'd7;
    bus_wr(17, 16'h0010, 1); rx_count = 5'd8;
    bus_rd(15, 16'h0010, "R11 set wins over clear");
    bus_wr(17, 16'h0010, 0);
    bus_rd(15, 16'h0000, "R11 clear alone");
    rx_count = 5'd0;

    // R10 undecoded
    bus_rd(17, 16'h0000, "R10 clear read zero");
    chk("R10 err on read", last_err, 1);
    bus_wr(10'h3F8, 16'h1234, 0);
    chk("R10 err on id write", last_err, 1);
    bus_wr(2, 16'h1234, 0);
    chk("R10 err on hole write", last_err, 1);
    bus_wr(15, 16'h07FF, 0);
    bus_rd(15, 16'h0000, "R10 raw write ignored");
    bus_rd(9, 16'hABCD, "R10 baud untouched");
    chk("R10 no err on good read", last_err, 0);
    bus_rd(2, 16'h0000, "R10 hole read");

    @(posedge clk); #1;
    while (sb.size() != 0) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule